// File: doc/BRIEF.md
# Four-Operand Accumulating Averager

This block forms the mean of sixteen unsigned bytes that arrive four per cycle. On each clock after reset is released it adds four new operands and the current running total in a single multioperand addition. The new total goes back into the total register. After four such cycles the total holds the sum of sixteen values, and a fixed right shift by four bits divides it by sixteen.

The adder is a tree of carry-save rows built from full-adder cells. It reduces the five inputs (four zero-extended operands and the register output) to a sum word and a carry word, which a ripple adder then resolves. An iteration counter marks completion with a done flag. From that point the total is frozen until the next synchronous reset, so the average stays on the output for as long as needed.

Top module: `quad_avg_accum`

## Requirements
- R1: A clock edge with `rst` high sets the total to zero, so on the following cycle `avg` reads 0 and `done` reads 0.
- R2: On each clock edge with `rst` low and `done` low, the total becomes the previous total plus `op_a + op_b + op_c + op_d` as sampled at that edge.
- R3: `avg` always equals the 12-bit total divided by 16 and truncated toward zero, that is, total bits 11 down to 4.
- R4: `done` goes high right after the fourth accumulating edge that follows reset release, and not earlier.
- R5: While `done` is high and `rst` is low, operand changes do not alter `avg`.
- R6: Sixteen operands of value 255 give a total of 4080 with no wrap-around, so `avg` reads 255.
- R7: A reset in the middle of a run discards the partial total and the count, and a full four new accumulations are then needed before `done` rises.
- R8: Once high, `done` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| op_c | input | 8 | Third unsigned operand |
| op_d | input | 8 | Fourth unsigned operand |
| avg | output | 8 | Running total divided by 16, truncated |
| done | output | 1 | High after the fourth accumulation until reset |

## Verification
The operands present at a rising edge are added into the total at that same edge. Both `avg` and `done` therefore show the effect one edge after the operands are applied, and a reset shows its effect one edge after `rst` is raised. The bench drives new operands and the reset level on the falling edge. It updates its own reference total as if the coming rising edge had already happened, and it compares the outputs on the next falling edge, which is exactly one register stage later. Random runs, all-maximum and all-zero runs, and a run cut short by reset all follow this same schedule.

// File: rtl/qavg_pkg.sv
package qavg_pkg;
  // number of fresh operands folded in per cycle
  localparam int NUM_NEW = 4;

  // bits needed to hold NUM_NEW*iters values of width w
  function automatic int total_width(input int w, input int iters);
    return w + $clog2(NUM_NEW * iters);
  endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 12
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] cy;

  for (genvar i = 0; i < W; i++) begin : g_bit
    fa_cell u_fa (.a(x[i]), .b(y[i]), .ci(z[i]), .s(s[i]), .co(cy[i]));
  end

  // carry word weighted one position up; top carry dropped (modular width)
  assign c = {cy[W-2:0], 1'b0};
endmodule

// File: rtl/rca_adder.sv
module rca_adder #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    fa_cell u_fa (.a(a[i]), .b(b[i]), .ci(chain[i]), .s(s[i]), .co(chain[i+1]));
  end

  logic unused_top;
  assign unused_top = chain[W];
endmodule

// File: rtl/madd5.sv
module madd5 #(
  parameter int W = 12
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  input  logic [W-1:0] in3,
  input  logic [W-1:0] in4,
  output logic [W-1:0] sum
);
  logic [W-1:0] s1, c1, s2, c2, s3, c3;

  // level 1: five operands become four
  csa_row #(.W(W)) u_l1 (.x(in0), .y(in1), .z(in2), .s(s1), .c(c1));
  // level 2: four become three
  csa_row #(.W(W)) u_l2 (.x(s1), .y(c1), .z(in3), .s(s2), .c(c2));
  // level 3: three become two
  csa_row #(.W(W)) u_l3 (.x(s2), .y(c2), .z(in4), .s(s3), .c(c3));
  // carry-propagate stage
  rca_adder #(.W(W)) u_cpa (.a(s3), .b(c3), .s(sum));
endmodule

// File: rtl/quad_avg_accum.sv
module quad_avg_accum #(
  parameter int W     = 8,
  parameter int ITERS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  output logic [W-1:0] avg,
  output logic         done
);
  import qavg_pkg::*;

  localparam int SW    = total_width(W, ITERS);
  localparam int SHIFT = SW - W;
  localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  logic [SW-1:0] total_q, total_d;
  logic [CW-1:0] iter_q;
  logic          done_q;

  madd5 #(.W(SW)) u_madd (
    .in0({{SHIFT{1'b0}}, op_a}),
    .in1({{SHIFT{1'b0}}, op_b}),
    .in2({{SHIFT{1'b0}}, op_c}),
    .in3({{SHIFT{1'b0}}, op_d}),
    .in4(total_q),
    .sum(total_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      total_q <= total_d;
      iter_q  <= iter_q + 1'b1;
      if (iter_q == LAST) done_q <= 1'b1;
    end
  end

  assign avg  = total_q[SW-1:SHIFT];
  assign done = done_q;
endmodule

// File: rtl/quad_avg_accum_chk.sv
module quad_avg_accum_chk #(
  parameter int W     = 8,
  parameter int ITERS = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] avg,
  input logic         done
);
  localparam int KW = $clog2(ITERS + 1) + 1;

  logic          seen = 1'b0;
  logic [KW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b1;
      since_rst <= '0;
    end else if (since_rst != KW'(ITERS)) begin
      since_rst <= since_rst + 1'b1;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (avg == '0 && !done));

  // R4
  a_r4_done_timing: assert property (@(posedge clk) disable iff (rst)
    seen |-> (done == (since_rst == KW'(ITERS))));

  // R8
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R5
  a_r5_hold_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(avg));

  // R2: unsigned operands never lower the running total
  a_r2_nondecreasing: assert property (@(posedge clk) disable iff (rst)
    (seen && !done) |=> (avg >= $past(avg)));
endmodule

bind quad_avg_accum quad_avg_accum_chk #(.W(W), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst(rst), .avg(avg), .done(done)
);

// File: tb/quad_avg_accum_test.sv
module quad_avg_accum_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic [7:0] avg;
  logic       done;

  int checks = 0;
  int fails  = 0;
  int m_total = 0;
  int m_cnt   = 0;
  bit m_done  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  quad_avg_accum uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .avg(avg), .done(done)
  );

  function automatic int exp_avg(input int total);
    return (total >> 4) & 8'hFF;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, model the coming posedge
  task automatic step(input bit r, input int a, input int b, input int c, input int d);
    rst = r; op_a = a[7:0]; op_b = b[7:0]; op_c = c[7:0]; op_d = d[7:0];
    if (r) begin
      m_total = 0; m_cnt = 0; m_done = 0;
    end else if (!m_done) begin
      m_total += a + b + c + d;
      m_cnt++;
      if (m_cnt == 4) m_done = 1;
    end
    @(negedge clk);
  endtask

  task automatic observe(input string tag_avg, input string tag_done);
    check(tag_avg, avg, exp_avg(m_total));
    check(tag_done, done, m_done);
  endtask

  task automatic do_reset();
    step(1, 0, 0, 0, 0);
    check("R1", avg, 0);
    check("R1", done, 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // random runs, extra cycles after done probe the hold (R5, R8)
    for (int run = 0; run < 20; run++) begin
      for (int k = 0; k < 7; k++) begin
        bit was_done = m_done;
        step(0, $urandom_range(255), $urandom_range(255),
                $urandom_range(255), $urandom_range(255));
        if (was_done) observe("R5", "R8");
        else          observe("R2", "R4");
      end
      do_reset();
    end

    // R6: all-maximum operands, no wrap
    for (int k = 0; k < 4; k++) begin
      step(0, 255, 255, 255, 255);
      observe("R3", "R4");
    end
    check("R6", avg, 255);
    step(0, 0, 0, 0, 0);
    check("R5", avg, 255);
    do_reset();

    // R3: truncation, total 15 -> 0, then 16 -> 1
    step(0, 15, 0, 0, 0);
    check("R3", avg, 0);
    step(0, 1, 0, 0, 0);
    check("R3", avg, 1);
    step(0, 0, 0, 0, 0);
    observe("R3", "R4");
    step(0, 0, 0, 0, 0);
    observe("R3", "R4");
    check("R4", done, 1);
    do_reset();

    // R7: reset mid-run restarts count and total
    step(0, 200, 200, 200, 200);
    step(0, 200, 200, 200, 200);
    do_reset();
    for (int k = 0; k < 3; k++) begin
      step(0, 10, 20, 30, 40);
      check("R7", done, 0);
    end
    step(0, 10, 20, 30, 40);
    check("R7", done, 1);
    check("R7", avg, 25);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule